// File: doc/BRIEF.md
# Banked Register Window Bus Slave

This block is a slave on a synchronous local bus. It answers one 16-byte register window. The window sits at a base address set by a parameter. Each access has two phases. In the first, the host pulls the address strobe low for one clock and presents the byte address and the direction. One clock later, the host pulls the cycle qualifier low and presents the active-low byte enables together with the write data. When the latched address falls inside the window, the block claims the cycle on an active-low claim output. A write commits on the first clock edge that sees the qualifier low. Read data stays valid for as long as the qualifier is held low. The cycle ends on the edge that samples the qualifier high again.

Byte offsets 0x0 through 0xD belong to banks. A 3-bit bank selector picks which bank those offsets reach. The selector sits in lane 2 of the top double word, at offset 0xE. The top double word also holds two interrupt registers, but only while bank 0 is selected: offset 0xC is the interrupt status and offset 0xD is the interrupt enable. The host may steer a write by byte, by half word or by full double word. One partial-decode rule applies. A full 32-bit write to the top double word changes only the bank selector, and bytes 0xC and 0xD are left untouched. The interrupt output is a high-true level.

The bus is a plain two-phase handshake with no back-pressure, so it has no valid/ready pairing. The event inputs are plain level-sampled controls.

Top module: `banked_reg_slave`

## Requirements
- R1: On the clock edge that samples the address strobe low with an address inside the window (address bits above bit 3 equal to the base), the claim output goes low after that edge. It goes high again after the first edge that samples the cycle qualifier high during the data phase. An address outside the window is never claimed.
- R2: A write commits on the first edge that samples the qualifier low. Only the lanes whose byte enable is low are stored, where lane n is data bits 8n+7..8n and byte offset 4*(address bits 3:2)+n.
- R3: Any offset can be read 8, 16 or 32 bits wide. The read data is valid while the qualifier is low in the data phase, lanes with a high byte enable read zero, and the read data is zero at all other times.
- R4: The bank selector is data bits 18:16 of a write to the top double word (offset 0xE) with lane 2 enabled. It resets to 0 and reads back in bits 18:16 with bits 31:24 and 23:19 zero. Offsets 0x0 to 0xB, and offsets 0xC and 0xD in banks other than 0, address separate storage for each bank.
- R5: A write to the top double word with all four byte enables low updates only the bank selector. Offsets 0xC and 0xD keep their values.
- R6: Writes 8 or 16 bits wide to offsets 0xC and 0xD store their enabled lanes.
- R7: A write with all byte enables high changes no register.
- R8: In bank 0, offset 0xC holds status bits, and each one is set while its event input is high. Writing 1 to a status bit clears it, and a set in the same cycle wins over the clear. Offset 0xD holds the enable bits. The interrupt output is high while any status bit has its enable bit set.
- R9: While the bank selector is NUM_BANKS or more, banked offsets read zero and writes to them are dropped. The selector itself stays readable and writable.
- R10: A write to an address outside the window changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ads_n | input | 1 | Active-low address strobe |
| cyc_n | input | 1 | Active-low cycle qualifier, follows the strobe one clock later |
| wr | input | 1 | Direction, 1 for write, sampled with the strobe |
| addr | input | ADDR_W | Byte address, sampled with the strobe; bits 1:0 ignored |
| be_n | input | 4 | Active-low byte enables, sampled with the qualifier |
| wdata | input | 32 | Write data, valid while the qualifier is low |
| ev_in | input | NUM_EV | Interrupt event levels |
| rdata | output | 32 | Read data |
| claim_n | output | 1 | Active-low cycle claim |
| irq | output | 1 | High-true level interrupt |

## Verification
The bench builds the block with its default parameters. The window sits at base 0x30, events are 8 bits wide, and there are four banks. Because four banks is fewer than the eight values the selector field can hold, selector values 4 to 7 can be reached, so the out-of-range rule can be tested. Addresses 0x40 and up test the miss rule. A bank switch from 0 to 2 and back shows that the storage of each bank is kept separately. The 32-bit write to the top double word is made while bank 0 is selected, so it could have reached the live interrupt enable, and the interrupt output shows whether it did.

// File: rtl/banked_pkg.sv
package banked_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA
  } bus_phase_e;

  localparam int          SEL_W      = 3;
  localparam int          BANK_BYTES = 14;
  localparam logic [1:0]  TOP_DW     = 2'd3;
  localparam int          SEL_LANE   = 2;
endpackage

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
  import banked_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              cyc_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              claim_n,
  output logic              wr_stb,
  output logic              rd_act,
  output logic [1:0]        dw
);
  localparam int WIN_W = ADDR_W - 4;

  bus_phase_e phase_q;
  logic       hit_q;
  logic       wr_q;
  logic       in_win;
  logic [1:0] unused_lsb;

  assign unused_lsb = addr[1:0];
  assign in_win     = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      hit_q   <= 1'b0;
      wr_q    <= 1'b0;
      dw      <= 2'd0;
      claim_n <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (!ads_n) begin
          phase_q <= PH_ADDR;
          hit_q   <= in_win;
          wr_q    <= wr;
          dw      <= addr[3:2];
          claim_n <= !in_win;
        end
        PH_ADDR: if (!cyc_n) phase_q <= PH_DATA;
        PH_DATA: if (cyc_n) begin
          phase_q <= PH_IDLE;
          claim_n <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign wr_stb = (phase_q == PH_ADDR) && !cyc_n && hit_q && wr_q;
  assign rd_act = (phase_q == PH_DATA) && !cyc_n && hit_q && !wr_q;

  // R1: a claim only ever starts right after a sampled strobe
  a_r1_claim_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(claim_n) |-> $past(!ads_n));

  localparam int UNUSED_WIN = WIN_W;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_EV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic              clr_we,
  input  logic [NUM_EV-1:0] clr_bits,
  input  logic              en_we,
  input  logic [NUM_EV-1:0] en_bits,
  output logic [NUM_EV-1:0] stat,
  output logic [NUM_EV-1:0] en,
  output logic              irq
);
  logic [NUM_EV-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr_mask) | ev_in;
      if (en_we) en <= en_bits;
    end
  end

  assign irq = |(stat & en);

  // R8: the line can only rise after an event or an enable write
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|ev_in) || $past(en_we)));
endmodule

// File: rtl/bank_store.sv
module bank_store
  import banked_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] bank,
  input  logic [1:0]       dw,
  input  logic [3:0]       byte_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_word
);
  logic [7:0] mem [NUM_BANKS][BANK_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int i = 0; i < BANK_BYTES; i++)
          mem[b][i] <= 8'h00;
    end else if (we) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int i = 0; i < BANK_BYTES; i++)
          if (32'(bank) == b && 32'(dw) == i / 4 && byte_we[i % 4]
              && !(b == 0 && i >= 12))
            mem[b][i] <= wdata[(i % 4) * 8 +: 8];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (32'(bank) == b)
        for (int l = 0; l < 4; l++)
          if (32'(dw) * 4 + l < BANK_BYTES)
            rd_word[l*8 +: 8] = mem[b][32'(dw) * 4 + l];
  end
endmodule

// File: rtl/banked_reg_slave.sv
module banked_reg_slave
  import banked_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE    = 8'h30,
  parameter int              NUM_BANKS = 4,
  parameter int              NUM_EV    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              cyc_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be_n,
  input  logic [31:0]       wdata,
  input  logic [NUM_EV-1:0] ev_in,
  output logic [31:0]       rdata,
  output logic              claim_n,
  output logic              irq
);
  localparam int SEL_LO = SEL_LANE * 8;

  logic             wr_stb, rd_act;
  logic [1:0]       dw;
  logic [SEL_W-1:0] bsel;
  logic [3:0]       lanes, st_we;
  logic             full, top_dw, bank0, bsel_we;
  logic [31:0]      st_word, word, lane_mask;
  logic [NUM_EV-1:0] stat, en;

  bus_cycle_fsm #(.ADDR_W(ADDR_W), .BASE(BASE)) i_fsm (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cyc_n(cyc_n), .wr(wr),
    .addr(addr), .claim_n(claim_n), .wr_stb(wr_stb), .rd_act(rd_act), .dw(dw)
  );

  assign lanes  = ~be_n;
  assign full   = (be_n == 4'b0000);
  assign top_dw = (dw == TOP_DW);
  assign bank0  = (bsel == '0);

  // top double word: lanes 0/1 only on narrow writes, lane 2 is the selector
  assign st_we   = top_dw ? {2'b00, lanes[1:0] & {2{!full}}} : lanes;
  assign bsel_we = wr_stb && top_dw && lanes[SEL_LANE];

  always_ff @(posedge clk) begin
    if (!rst_n)       bsel <= '0;
    else if (bsel_we) bsel <= wdata[SEL_LO +: SEL_W];
  end

  bank_store #(.NUM_BANKS(NUM_BANKS)) i_store (
    .clk(clk), .rst_n(rst_n), .we(wr_stb), .bank(bsel), .dw(dw),
    .byte_we(st_we), .wdata(wdata), .rd_word(st_word)
  );

  irq_ctrl #(.NUM_EV(NUM_EV)) i_irq (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in),
    .clr_we(wr_stb && top_dw && bank0 && lanes[0] && !full),
    .clr_bits(wdata[NUM_EV-1:0]),
    .en_we(wr_stb && top_dw && bank0 && lanes[1] && !full),
    .en_bits(wdata[8 +: NUM_EV]),
    .stat(stat), .en(en), .irq(irq)
  );

  always_comb begin
    word = st_word;
    if (top_dw) begin
      word = '0;
      word[SEL_LO +: SEL_W] = bsel;
      word[15:0] = bank0 ? {8'(en), 8'(stat)} : st_word[15:0];
    end
  end

  generate
    for (genvar l = 0; l < 4; l++) begin : g_mask
      assign lane_mask[l*8 +: 8] = {8{lanes[l]}};
    end
  endgenerate

  assign rdata = rd_act ? (word & lane_mask) : 32'h0;

  // R4: the selector moves only on a committed write cycle
  a_r4_sel_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bsel) |-> $past(wr_stb));
  // R5: a full-width write to the top double word leaves the enable alone
  a_r5_full_top_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && top_dw && be_n == 4'b0000) |=> $stable(en));
  // R7: a write with no lane enabled changes neither selector nor enable
  a_r7_no_lane_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && be_n == 4'b1111) |=> ($stable(bsel) && $stable(en)));
endmodule

// File: tb/test_banked_reg_slave.sv
module test_banked_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic        w;
    logic [7:0]  a;
    logic [3:0]  be;
    logic [31:0] d;
    logic [31:0] x;
    logic        c;
    logic [3:0]  r;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h30, 4'b0000, 32'h11223344, 32'h0,        1'b1, 4'd2},  // R2 full write
    '{1'b0, 8'h30, 4'b0000, 32'h0,        32'h11223344, 1'b1, 4'd3},  // R3 32-bit read
    '{1'b0, 8'h30, 4'b1100, 32'h0,        32'h00003344, 1'b1, 4'd3},  // R3 16-bit read
    '{1'b0, 8'h31, 4'b0111, 32'h0,        32'h11000000, 1'b1, 4'd3},  // R3 8-bit read
    '{1'b1, 8'h34, 4'b1101, 32'hAABBCCDD, 32'h0,        1'b1, 4'd2},  // R2 byte write
    '{1'b0, 8'h34, 4'b0000, 32'h0,        32'h0000CC00, 1'b1, 4'd2},  // R2 single lane
    '{1'b1, 8'h3C, 4'b0000, 32'h7F02A5A5, 32'h0,        1'b1, 4'd5},  // R5 full top write
    '{1'b0, 8'h3C, 4'b0000, 32'h0,        32'h00020000, 1'b1, 4'd4},  // R4 selector readback
    '{1'b1, 8'h30, 4'b0000, 32'hCAFEF00D, 32'h0,        1'b1, 4'd4},  // R4 bank 2 write
    '{1'b0, 8'h30, 4'b0000, 32'h0,        32'hCAFEF00D, 1'b1, 4'd4},  // R4 bank 2 read
    '{1'b1, 8'h3C, 4'b1100, 32'h0000BEEF, 32'h0,        1'b1, 4'd6},  // R6 16-bit top
    '{1'b0, 8'h3C, 4'b0000, 32'h0,        32'h0002BEEF, 1'b1, 4'd6},  // R6 readback
    '{1'b1, 8'h3E, 4'b1011, 32'h00000000, 32'h0,        1'b1, 4'd4},  // R4 back to bank 0
    '{1'b0, 8'h30, 4'b0000, 32'h0,        32'h11223344, 1'b1, 4'd4},  // R4 bank 0 kept
    '{1'b0, 8'h3C, 4'b0000, 32'h0,        32'h00000000, 1'b1, 4'd5},  // R5 enable untouched
    '{1'b1, 8'h40, 4'b0000, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd1},  // R1 R10 miss
    '{1'b0, 8'h30, 4'b0000, 32'h0,        32'h11223344, 1'b1, 4'd10}, // R10 no effect
    '{1'b1, 8'h30, 4'b1111, 32'h00000000, 32'h0,        1'b1, 4'd7},  // R7 no lanes
    '{1'b0, 8'h30, 4'b0000, 32'h0,        32'h11223344, 1'b1, 4'd7}   // R7 unchanged
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1, cyc_n = 1'b1, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] wdata = '0;
  logic [7:0]  ev_in = '0;
  logic [31:0] rdata;
  logic        claim_n, irq;
  int          total = 0, bad = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_reg_slave i_banked_reg_slave (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cyc_n(cyc_n), .wr(wr),
    .addr(addr), .be_n(be_n), .wdata(wdata), .ev_in(ev_in),
    .rdata(rdata), .claim_n(claim_n), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [3:0] b,
                     input logic [31:0] d, input logic exp_c, input string tag,
                     output logic [31:0] got);
    @(negedge clk); ads_n = 1'b0; addr = a; wr = w;
    @(negedge clk); ads_n = 1'b1;
    chk({tag, " R1 claim"}, {31'b0, claim_n}, {31'b0, !exp_c});
    cyc_n = 1'b0; be_n = b; wdata = d;
    @(negedge clk); got = rdata;
    cyc_n = 1'b1; be_n = 4'hF;
    @(negedge clk);
    chk({tag, " R1 release"}, {31'b0, claim_n}, 32'h1);
    chk({tag, " R3 idle rdata"}, rdata, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset claim", {31'b0, claim_n}, 32'h1);
    chk("R8 reset irq", {31'b0, irq}, 32'h0);
    chk("R3 reset rdata", rdata, 32'h0);

    for (int k = 0; k < NV; k++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[k].r, k);
      bus(VEC[k].w, VEC[k].a, VEC[k].be, VEC[k].d, VEC[k].c, t, rd);
      chk({t, " data"}, rd, VEC[k].x);
    end

    // R9: selector beyond the bank count
    bus(1'b1, 8'h3C, 4'b1011, 32'h00050000, 1'b1, "R9 sel5", rd);
    bus(1'b1, 8'h30, 4'b0000, 32'h12345678, 1'b1, "R9 wr", rd);
    bus(1'b0, 8'h30, 4'b0000, 32'h0, 1'b1, "R9 rd", rd);
    chk("R9 banked read zero", rd, 32'h0);
    bus(1'b0, 8'h3C, 4'b0000, 32'h0, 1'b1, "R9 sel rd", rd);
    chk("R9 selector readable", rd, 32'h00050000);
    bus(1'b1, 8'h3C, 4'b1011, 32'h00020000, 1'b1, "R9 sel2", rd);
    bus(1'b0, 8'h30, 4'b0000, 32'h0, 1'b1, "R9 rd2", rd);
    chk("R9 write dropped", rd, 32'hCAFEF00D);
    bus(1'b1, 8'h3C, 4'b1011, 32'h00000000, 1'b1, "R8 sel0", rd);

    // R8: event, enable, clear
    @(negedge clk); ev_in = 8'h02;
    @(negedge clk); ev_in = 8'h00;
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
    bus(1'b0, 8'h3C, 4'b1110, 32'h0, 1'b1, "R8 stat", rd);
    chk("R8 status set", rd, 32'h00000002);
    bus(1'b1, 8'h3C, 4'b1101, 32'h00000200, 1'b1, "R6 en", rd);
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    bus(1'b1, 8'h3C, 4'b0000, 32'h0000FFFF, 1'b1, "R5 full", rd);
    chk("R5 irq kept", {31'b0, irq}, 32'h1);
    bus(1'b1, 8'h3C, 4'b1110, 32'h00000002, 1'b1, "R8 w1c", rd);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    bus(1'b0, 8'h3C, 4'b0000, 32'h0, 1'b1, "R8 rd", rd);
    chk("R8 regs after clear", rd, 32'h00000200);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule